// File: doc/BRIEF.md
# Protected System Clock Controller

This block decides which clock enables a chip's logic sees. It runs on the main clock and produces single-cycle enable pulses at the rate of that clock (f1) and at a programmed fraction of it. It can also hand the system clock over to a slow sub-clock, which arrives as a one-cycle `sub_tick` strobe. A fixed divider on that strobe gives a slower sub-clock rate. One of those sub-clock rates is sent out on `fc132_ce`.

Software controls the block through two byte-wide control registers on a plain address/data/strobe bus. Every write is discarded unless the `prot_en` input is high. Source switching is guarded so that the system clock can only move to a source that is enabled and reported stable. The block also gates peripheral enables in wait mode and halts every enable in stop mode. A wake input leaves stop mode. Entering stop mode forces certain drive and divider bits, depending on which source was running. The oscillator drive-strength bits are storage only.

Top module: `sysclk_ctl`

## Requirements
- R1: Control register A sits at bus address 0 and resets to 0x48. Control register B sits at address 1 and resets to 0x20. Reads of addresses 2 and 3 return 0.
- R2: A write with `prot_en` low changes neither register. A stop request written this way is not acted on.
- R3: Register A bits [1:0] pick what `clkout_ce` carries: 0 = nothing, with `clkout_port` high; 1 = the sub-clock strobe `fc1_ce`; 2 = `f1_ce`, which pulses every cycle; 3 = the divided pulse `div_ce`.
- R4: When register A bit 6 is 1, the divider ratio is 8 and register B bits [7:6] are ignored. When bit 6 is 0, register B bits [7:6] give the ratio: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 16.
- R5: After the clock edge that changes the ratio to N, the first `div_ce` pulse is seen in the (N+1)-th cycle. Pulses then repeat every N cycles, each one cycle long.
- R6: Register A bit 7 (1 = system clock from the sub-clock) rises only if three conditions all hold: the old bit 4 (sub-clock enable) is 1, the written bit 4 is 1, and `sub_stable` is high. Otherwise bit 7 keeps its value while the other written bits take effect.
- R7: Register A bit 5 = 1 stops `f1_ce` and `div_ce`. Bit 7 falls back to 0 only if the old bit 5 is 0 and `main_stable` is high.
- R8: `wait_req` holds `cpu_ce` at 0. When register A bit 2 is also 1, `periph_ce` is held at 0 as well. `fc1_ce` and `fc132_ce` keep running in wait mode.
- R9: Writing register B with bit 0 = 1 enters stop mode. The entry forces register A bit 3 and register B bit 5 to 1. It also sets register A bit 6 to 1 if register A bit 7 is 0, and leaves bit 6 unchanged if bit 7 is 1.
- R10: In stop mode, all enable outputs are 0 and `stop_mode` is 1. A `wake` pulse clears register B bit 0.
- R11: `fc132_ce` equals `fc1_ce` when register B bit 4 is 1. When bit 4 is 0, it pulses once every SUB_DIV sub-clock strobes.
- R12: Register B bits [3:1] always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data (combinational) |
| prot_en | input | 1 | Write permission |
| sub_tick | input | 1 | Sub-clock edge strobe |
| sub_stable | input | 1 | Sub-clock has settled |
| main_stable | input | 1 | Main clock has settled |
| wait_req | input | 1 | Wait mode active |
| wake | input | 1 | Interrupt or wake event |
| sys_ce | output | 1 | System clock enable |
| cpu_ce | output | 1 | System enable gated by wait |
| periph_ce | output | 1 | Peripheral clock enable |
| f1_ce | output | 1 | Undivided main enable |
| div_ce | output | 1 | Divided main enable |
| fc1_ce | output | 1 | Sub-clock enable |
| fc132_ce | output | 1 | Selected sub-clock rate |
| clkout_ce | output | 1 | Clock output pin value |
| clkout_port | output | 1 | Pin left as plain port |
| main_osc_on | output | 1 | Main oscillator running |
| sub_osc_on | output | 1 | Sub oscillator running |
| stop_mode | output | 1 | Stop mode active |

## Verification
The bench builds the block with its defaults, ADDR_W = 2 and SUB_DIV = 32. With ADDR_W = 2, the two unused addresses can be read to confirm that they return 0. With SUB_DIV = 32, a 256-cycle window with a sub-clock strobe every fourth cycle gives exactly two slow `fc132_ce` pulses, so the slow rate and the fast rate can be told apart exactly. With ratio 16 as the largest divider, the restart latency and the pulse period of every ratio can be measured to the cycle.

// File: rtl/sysclk_pkg.sv
`timescale 1ns/1ps
package sysclk_pkg;
    localparam int DATA_W    = 8;
    localparam int RATIO_MAX = 16;
    localparam int CNT_W     = $clog2(RATIO_MAX);
    localparam int RATIO_W   = CNT_W + 1;
    localparam int REGA_OFS  = 0;
    localparam int REGB_OFS  = 1;

    typedef enum logic [1:0] {
        OUT_PORT   = 2'd0,
        OUT_SUB    = 2'd1,
        OUT_FAST   = 2'd2,
        OUT_DIVIDE = 2'd3
    } clkout_sel_e;

    typedef struct packed {
        logic        sys_sub;
        logic        div8;
        logic        main_halt;
        logic        sub_en;
        logic        sub_drive;
        logic        wait_pgate;
        clkout_sel_e out_sel;
    } ctl_a_t;

    typedef struct packed {
        logic [1:0] div_sel;
        logic       main_drive;
        logic       fc_fast;
        logic [2:0] unused_z;
        logic       stop;
    } ctl_b_t;

    localparam ctl_a_t CTL_A_RST = ctl_a_t'(8'h48);
    localparam ctl_b_t CTL_B_RST = ctl_b_t'(8'h20);

    function automatic logic [RATIO_W-1:0] div_ratio(input logic force8,
                                                     input logic [1:0] sel);
        if (force8) return RATIO_W'(8);
        case (sel)
            2'd0:    return RATIO_W'(1);
            2'd1:    return RATIO_W'(2);
            2'd2:    return RATIO_W'(4);
            default: return RATIO_W'(16);
        endcase
    endfunction
endpackage

// File: rtl/sysclk_regs.sv
`timescale 1ns/1ps
module sysclk_regs
    import sysclk_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              we,
    input  logic              prot_en,
    input  logic              sub_stable,
    input  logic              main_stable,
    input  logic              wake,
    output ctl_a_t            ra,
    output ctl_b_t            rb,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(REGA_OFS);
    localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(REGB_OFS);

    ctl_a_t na, wa;
    ctl_b_t nb, wb;
    logic   hit_a, hit_b;

    always_comb begin
        hit_a = we && prot_en && (addr == ADR_A);
        hit_b = we && prot_en && (addr == ADR_B);
        wa    = ctl_a_t'(wdata);
        wb    = ctl_b_t'(wdata);
        na    = ra;
        nb    = rb;
        if (hit_a) begin
            na         = wa;
            na.sys_sub = ra.sys_sub;
            // move to sub-clock: enable must already be on, stay on, and be settled
            if (!ra.sys_sub && wa.sys_sub && ra.sub_en && wa.sub_en && sub_stable)
                na.sys_sub = 1'b1;
            // move back to main: main must be running and settled
            if (ra.sys_sub && !wa.sys_sub && !ra.main_halt && main_stable)
                na.sys_sub = 1'b0;
        end
        if (hit_b) begin
            nb          = wb;
            nb.unused_z = '0;
            if (wb.stop) begin
                nb.main_drive = 1'b1;
                na.sub_drive  = 1'b1;
                if (!ra.sys_sub) na.div8 = 1'b1;
            end
        end
        if (wake) nb.stop = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ra <= CTL_A_RST;
            rb <= CTL_B_RST;
        end else begin
            ra <= na;
            rb <= nb;
        end
    end

    always_comb begin
        if (addr == ADR_A)      rdata = ra;
        else if (addr == ADR_B) rdata = rb;
        else                    rdata = '0;
    end
endmodule

// File: rtl/sysclk_div.sv
`timescale 1ns/1ps
module sysclk_div
    import sysclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic [RATIO_W-1:0] ratio,
    output logic               pulse
);
    logic [RATIO_W-1:0] ratio_q;
    logic [CNT_W-1:0]   cnt;
    logic               changed, at_end;

    assign changed = (ratio != ratio_q);
    assign at_end  = ({1'b0, cnt} == (ratio - RATIO_W'(1)));
    assign pulse   = run && !changed && at_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            ratio_q <= '0;
            cnt     <= '0;
        end else begin
            ratio_q <= ratio;
            if (!run || changed || at_end) cnt <= '0;
            else                           cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sysclk_subdiv.sv
`timescale 1ns/1ps
module sysclk_subdiv #(
    parameter int SUB_DIV = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic tick,
    output logic pulse
);
    generate
        if (SUB_DIV <= 1) begin : g_pass
            assign pulse = en && tick;
        end else begin : g_count
            localparam int W = $clog2(SUB_DIV);
            logic [W-1:0] cnt;
            logic         last;
            assign last  = (cnt == W'(SUB_DIV - 1));
            assign pulse = en && tick && last;
            always_ff @(posedge clk) begin
                if (rst || !en)  cnt <= '0;
                else if (tick)   cnt <= last ? '0 : cnt + 1'b1;
            end
        end
    endgenerate
endmodule

// File: rtl/sysclk_ctl.sv
`timescale 1ns/1ps
module sysclk_ctl
    import sysclk_pkg::*;
#(
    parameter int ADDR_W  = 2,
    parameter int SUB_DIV = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    output logic [7:0]        bus_rdata,
    input  logic              prot_en,
    input  logic              sub_tick,
    input  logic              sub_stable,
    input  logic              main_stable,
    input  logic              wait_req,
    input  logic              wake,
    output logic              sys_ce,
    output logic              cpu_ce,
    output logic              periph_ce,
    output logic              f1_ce,
    output logic              div_ce,
    output logic              fc1_ce,
    output logic              fc132_ce,
    output logic              clkout_ce,
    output logic              clkout_port,
    output logic              main_osc_on,
    output logic              sub_osc_on,
    output logic              stop_mode
);
    ctl_a_t             ra;
    ctl_b_t             rb;
    logic               main_run, sub_run, slow_ce;
    logic [RATIO_W-1:0] ratio;

    sysclk_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
        .prot_en(prot_en), .sub_stable(sub_stable), .main_stable(main_stable),
        .wake(wake), .ra(ra), .rb(rb), .rdata(bus_rdata)
    );

    assign main_run = !rb.stop && !ra.main_halt;
    assign sub_run  = !rb.stop && ra.sub_en;
    assign ratio    = div_ratio(ra.div8, rb.div_sel);

    sysclk_div u_div (
        .clk(clk), .rst(rst), .run(main_run), .ratio(ratio), .pulse(div_ce)
    );

    sysclk_subdiv #(.SUB_DIV(SUB_DIV)) u_sub (
        .clk(clk), .rst(rst), .en(sub_run), .tick(sub_tick), .pulse(slow_ce)
    );

    assign f1_ce     = main_run;
    assign fc1_ce    = sub_run && sub_tick;
    assign fc132_ce  = rb.fc_fast ? fc1_ce : slow_ce;
    assign sys_ce    = ra.sys_sub ? fc1_ce : div_ce;
    assign cpu_ce    = sys_ce && !wait_req;
    assign periph_ce = sys_ce && !(wait_req && ra.wait_pgate);

    always_comb begin
        case (ra.out_sel)
            OUT_SUB:    clkout_ce = fc1_ce;
            OUT_FAST:   clkout_ce = f1_ce;
            OUT_DIVIDE: clkout_ce = div_ce;
            default:    clkout_ce = 1'b0;
        endcase
    end

    assign clkout_port = (ra.out_sel == OUT_PORT);
    assign main_osc_on = main_run;
    assign sub_osc_on  = sub_run;
    assign stop_mode   = rb.stop;
endmodule

// File: rtl/sysclk_ctl_chk.sv
`timescale 1ns/1ps
module sysclk_ctl_chk (
    input logic       clk,
    input logic       rst,
    input logic       we,
    input logic       prot_en,
    input logic       wake,
    input logic       sub_stable,
    input logic       main_stable,
    input logic       wait_req,
    input logic [7:0] ra,
    input logic [7:0] rb,
    input logic       sys_ce,
    input logic       periph_ce,
    input logic       f1_ce,
    input logic       div_ce,
    input logic       fc1_ce,
    input logic       fc132_ce,
    input logic       clkout_ce
);
    p_locked_r2: assert property (@(posedge clk) disable iff (rst)
        (we && !prot_en && !wake) |=> ($stable(ra) && $stable(rb)));

    p_sub_guard_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(ra[7]) |-> ($past(ra[4]) && $past(sub_stable)));

    p_main_guard_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ra[7]) |-> ($past(main_stable) && !$past(ra[5])));

    p_div_single_r5: assert property (@(posedge clk) disable iff (rst)
        (div_ce && (ra[6] || rb[7:6] != 2'd0)) |=> !div_ce);

    p_wait_gate_r8: assert property (@(posedge clk) disable iff (rst)
        (wait_req && ra[2]) |-> !periph_ce);

    p_stop_bits_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(rb[0]) |-> (ra[3] && rb[5]));

    p_stop_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        rb[0] |-> !(sys_ce || periph_ce || f1_ce || div_ce || fc1_ce || fc132_ce || clkout_ce));
endmodule

bind sysclk_ctl sysclk_ctl_chk u_chk (
    .clk(clk), .rst(rst), .we(bus_we), .prot_en(prot_en), .wake(wake),
    .sub_stable(sub_stable), .main_stable(main_stable), .wait_req(wait_req),
    .ra(ra), .rb(rb), .sys_ce(sys_ce), .periph_ce(periph_ce), .f1_ce(f1_ce),
    .div_ce(div_ce), .fc1_ce(fc1_ce), .fc132_ce(fc132_ce), .clkout_ce(clkout_ce)
);

// File: tb/sysclk_ctl_test.sv
`timescale 1ns/1ps
module sysclk_ctl_test;
    localparam int SUB_DIV = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic       prot_en = 1'b1, sub_tick = 1'b0, sub_stable = 1'b0, main_stable = 1'b1;
    logic       wait_req = 1'b0, wake = 1'b0;
    logic       sys_ce, cpu_ce, periph_ce, f1_ce, div_ce, fc1_ce, fc132_ce;
    logic       clkout_ce, clkout_port, main_osc_on, sub_osc_on, stop_mode;
    logic       sub_gen = 1'b0;
    logic [7:0] tcnt = '0;
    int         nchk = 0, nerr = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        tcnt     <= tcnt + 1'b1;
        sub_tick <= sub_gen && (tcnt[1:0] == 2'd0);
    end

    sysclk_ctl #(.ADDR_W(2), .SUB_DIV(SUB_DIV)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .prot_en(prot_en),
        .sub_tick(sub_tick), .sub_stable(sub_stable), .main_stable(main_stable),
        .wait_req(wait_req), .wake(wake), .sys_ce(sys_ce), .cpu_ce(cpu_ce),
        .periph_ce(periph_ce), .f1_ce(f1_ce), .div_ce(div_ce), .fc1_ce(fc1_ce),
        .fc132_ce(fc132_ce), .clkout_ce(clkout_ce), .clkout_port(clkout_port),
        .main_osc_on(main_osc_on), .sub_osc_on(sub_osc_on), .stop_mode(stop_mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; sub_gen = 1'b0; sub_stable = 1'b0; main_stable = 1'b1;
        wait_req = 1'b0; wake = 1'b0; prot_en = 1'b1; bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        bus_addr = a;
        #1 v = int'(bus_rdata);
    endtask

    function automatic logic pick(input int w);
        case (w)
            0: return sys_ce;      1: return cpu_ce;    2: return periph_ce;
            3: return f1_ce;       4: return div_ce;    5: return fc1_ce;
            6: return fc132_ce;    default: return clkout_ce;
        endcase
    endfunction

    task automatic count(input int w, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c += int'(pick(w));
        end
    endtask

    // first pulse latency after a ratio-changing write, then the period
    task automatic measure(input string tag, input int n);
        int k, p;
        k = 1;
        while (!div_ce && k < 100) begin @(negedge clk); k++; end
        check({tag, " first pulse cycle"}, k, n + 1);
        p = 0;
        do begin @(negedge clk); p++; end while (!div_ce && p < 100);
        check({tag, " period"}, p, n);
    endtask

    task automatic t_reset();
        int v;
        do_reset();
        rd(2'd0, v); check("R1 reg A reset", v, 8'h48);
        rd(2'd1, v); check("R1 reg B reset", v, 8'h20);
        rd(2'd2, v); check("R1 unused address", v, 0);
        check("R1 not in stop", int'(stop_mode), 0);
    endtask

    task automatic t_protect();
        int v, c;
        do_reset();
        prot_en = 1'b0;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        rd(2'd0, v); check("R2 reg A locked", v, 8'h48);
        rd(2'd1, v); check("R2 reg B locked", v, 8'h20);
        count(3, 16, c); check("R2 f1 still runs", c, 16);
        prot_en = 1'b1;
        wr(2'd1, 8'hFE);
        rd(2'd1, v); check("R12 reserved bits zero", v, 8'hF0);
    endtask

    task automatic t_divider();
        do_reset();
        wr(2'd0, 8'h08); measure("R4 R5 ratio 1", 1);
        wr(2'd1, 8'h60); measure("R4 R5 ratio 2", 2);
        wr(2'd1, 8'hA0); measure("R4 R5 ratio 4", 4);
        wr(2'd1, 8'hE0); measure("R4 R5 ratio 16", 16);
        wr(2'd0, 8'h48); measure("R4 R5 forced 8", 8);
    endtask

    task automatic t_clkout();
        int c;
        int exp_c[4] = '{0, 8, 32, 8};
        do_reset();
        sub_gen = 1'b1;
        wr(2'd1, 8'hA0);
        for (int s = 0; s < 4; s++) begin
            wr(2'd0, 8'(8'h10 | s));
            repeat (20) @(negedge clk);
            count(7, 32, c);
            check($sformatf("R3 clkout sel %0d", s), c, exp_c[s]);
            check($sformatf("R3 port flag sel %0d", s), int'(clkout_port), int'(s == 0));
        end
    endtask

    task automatic t_switch();
        int v, c;
        do_reset();
        sub_gen = 1'b1;
        wr(2'd0, 8'hC8); rd(2'd0, v); check("R6 no sub enable", v, 8'h48);
        wr(2'd0, 8'hD8); rd(2'd0, v); check("R6 same-write enable", v, 8'h58);
        wr(2'd0, 8'hD8); rd(2'd0, v); check("R6 sub not stable", v, 8'h58);
        sub_stable = 1'b1;
        wr(2'd0, 8'hD8); rd(2'd0, v); check("R6 switch accepted", v, 8'hD8);
        count(0, 32, c); check("R6 sys follows sub", c, 8);
        wr(2'd0, 8'hF8);
        count(3, 16, c); check("R7 f1 halted", c, 0);
        count(4, 16, c); check("R7 div halted", c, 0);
        wr(2'd0, 8'h78); rd(2'd0, v); check("R7 back blocked by halt", v, 8'hF8);
        wr(2'd0, 8'hD8);
        main_stable = 1'b0;
        wr(2'd0, 8'h58); rd(2'd0, v); check("R7 back blocked unstable", v, 8'hD8);
        main_stable = 1'b1;
        wr(2'd0, 8'h58); rd(2'd0, v); check("R7 back accepted", v, 8'h58);
    endtask

    task automatic t_wait();
        int c;
        do_reset();
        sub_gen = 1'b1;
        wr(2'd0, 8'h5C);
        wait_req = 1'b1;
        repeat (4) @(negedge clk);
        count(2, 64, c); check("R8 periph gated", c, 0);
        count(1, 64, c); check("R8 cpu gated", c, 0);
        count(5, 64, c); check("R8 sub clock exempt", c, 16);
        wr(2'd0, 8'h58);
        repeat (4) @(negedge clk);
        count(2, 64, c); check("R8 periph runs", c, 8);
        wait_req = 1'b0;
    endtask

    task automatic t_stop();
        int v, c;
        do_reset();
        sub_gen = 1'b1;
        wr(2'd0, 8'h12);
        wr(2'd1, 8'h00);
        wr(2'd1, 8'h01);
        rd(2'd0, v); check("R9 reg A from main", v, 8'h5A);
        rd(2'd1, v); check("R9 reg B from main", v, 8'h21);
        check("R10 stop flag", int'(stop_mode), 1);
        count(3, 32, c); check("R10 f1 halted", c, 0);
        count(5, 32, c); check("R10 fc1 halted", c, 0);
        count(7, 32, c); check("R10 clkout halted", c, 0);
        @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
        rd(2'd1, v); check("R10 wake clears stop", v, 8'h20);
        count(3, 16, c); check("R10 f1 resumes", c, 16);
        do_reset();
        sub_gen = 1'b1; sub_stable = 1'b1;
        wr(2'd0, 8'h10);
        wr(2'd0, 8'h90);
        wr(2'd1, 8'h01);
        rd(2'd0, v); check("R9 reg A from sub keeps bit 6", v, 8'h98);
    endtask

    task automatic t_fc132();
        int c;
        do_reset();
        sub_gen = 1'b1;
        wr(2'd0, 8'h58);
        wr(2'd1, 8'h20);
        count(6, 256, c); check("R11 slow rate", c, 64 / SUB_DIV);
        wr(2'd1, 8'h30);
        count(6, 256, c); check("R11 fast rate", c, 64);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        t_reset();
        t_protect();
        t_divider();
        t_clkout();
        t_switch();
        t_wait();
        t_stop();
        t_fc132();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule